// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block collects 32 level-sensitive peripheral interrupt inputs and drives five CPU interrupt lines, named IP2 to IP6. Software gives each source its own enable bit in a mask register. It also gives each source a 4-bit route code, held in four route registers. The route code picks the single CPU line that the source can assert. A CPU line is high while at least one source is high, enabled and routed to that line.

Several sources may share one CPU line. A handler then reads the mask register and the status register, which shows the sampled raw source levels. The AND of the two tells it which enabled source is active. To acknowledge or mask a level source, software clears its enable bit. To end the interrupt, software sets the bit again.

All registers sit on a simple single-cycle register bus. Writes take effect at the clock edge. Reads are combinational from the address. The CPU lines are registered.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0, every CPU line is low, and the route registers read 0x32622225, 0x50040000, 0x00000000 and 0x00000000 (addresses 2 to 5).
- R2: A write to address 0 loads the mask register, and a read of address 0 returns it. Bit s set to 1 enables source s.
- R3: A read of address 1 returns the source levels sampled at the latest clock edge, regardless of the mask.
- R4: A write to address 1 changes no register, and it has no effect on the CPU lines.
- R5: Route register k (address 2+k, k = 0..3) holds the codes for sources 31-8k down to 24-8k. Source s uses bits [4*(s mod 8)+3 : 4*(s mod 8)] of its route register. Code values 2 to 6 select IP2 to IP6, which are cpu_line_o bits 0 to 4. Any other code routes the source to no line.
- R6: At each clock edge, every CPU line is loaded with the OR, over all sources, of (source high AND enable bit set AND routed to that line). Source levels and register values are taken as they stand just before the edge.
- R7: Clearing an enable bit while its source stays high leaves the line high for one more edge. The line falls at the edge that follows the write.
- R8: When two enabled sources share a line, the line stays high until both sources are low.
- R9: With the default routing and every source enabled:
  - source 31 drives IP3;
  - sources 30, 28, 27, 26 and 25 drive IP2;
  - source 29 drives IP6;
  - sources 24 and 23 drive IP5;
  - source 20 drives IP4;
  - all other sources drive nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level interrupt sources, bit s is source s |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address (0 mask, 1 status, 2..5 route) |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data for addr_i, combinational |
| cpu_line_o | output | 5 | CPU interrupt lines, bit 0 = IP2 ... bit 4 = IP6 |

## Verification
A corrupted enable bit or route code shows up on the CPU lines at the first edge where the affected source is high. It also shows up at once on the read data when that register is read back. A stale status sample is exposed by reading address 1 one edge after the sources change. A misplaced route nibble sends a source to the wrong line. That error is visible in the same cycle in which the source is first seen. The random phase reprograms routes with both legal and illegal codes, so a wrong decode or a wrong field position is reached within a few hundred cycles.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int NSRC      = 32;
    localparam int NLINE     = 5;
    localparam int CODE_W    = 4;
    localparam int PER_REG   = 8;
    localparam int NROUTE    = NSRC / PER_REG;
    localparam int LINE_BASE = 2;
    localparam int ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK   = 3'd0,
        REG_STAT   = 3'd1,
        REG_ROUTE0 = 3'd2,
        REG_ROUTE1 = 3'd3,
        REG_ROUTE2 = 3'd4,
        REG_ROUTE3 = 3'd5
    } reg_sel_e;

    function automatic logic [NSRC-1:0] route_default(input int k);
        case (k)
            0:       return 32'h3262_2225;
            1:       return 32'h5004_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/icu_regs.sv
module icu_regs
    import icu_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NSRC-1:0]                   src_i,
    input  logic                              wr_en_i,
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic [NSRC-1:0]                   wr_data_i,
    output logic [NSRC-1:0]                   rd_data_o,
    output logic [NSRC-1:0]                   mask_o,
    output logic [NROUTE-1:0][NSRC-1:0]       route_o
);

    logic [NSRC-1:0]             mask_q;
    logic [NSRC-1:0]             stat_q;
    logic [NROUTE-1:0][NSRC-1:0] route_q;

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en_i && addr_i == REG_MASK)
            mask_q <= wr_data_i;
    end

    // Status register: samples the raw source levels at every edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= '0;
        else
            stat_q <= src_i;
    end

    // Route registers, one per group of sources
    for (genvar k = 0; k < NROUTE; k++) begin : g_route
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ROUTE0 + k);

        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[k] <= route_default(k);
            else if (wr_en_i && addr_i == MY_ADDR)
                route_q[k] <= wr_data_i;
        end

        AST_ROUTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == MY_ADDR) |=> route_q[k] == $past(wr_data_i)); // R5
    end

    // Combinational read mux
    always_comb begin
        rd_data_o = '0;
        unique case (addr_i)
            REG_MASK:   rd_data_o = mask_q;
            REG_STAT:   rd_data_o = stat_q;
            REG_ROUTE0: rd_data_o = route_q[0];
            REG_ROUTE1: rd_data_o = route_q[1];
            REG_ROUTE2: rd_data_o = route_q[2];
            REG_ROUTE3: rd_data_o = route_q[3];
            default:    rd_data_o = '0;
        endcase
    end

    assign mask_o  = mask_q;
    assign route_o = route_q;

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == REG_MASK) |=> mask_q == $past(wr_data_i)); // R2

    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == REG_STAT) |=> ($stable(mask_q) && $stable(route_q))); // R4

endmodule

// File: rtl/icu_route.sv
module icu_route
    import icu_pkg::*;
(
    input  logic [NROUTE-1:0][NSRC-1:0] route_i,
    output logic [NLINE-1:0][NSRC-1:0]  hit_o
);

    // Decode each source's code field into a one-of-lines routing vector
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int REG_IDX = (NSRC - 1 - s) / PER_REG;
        localparam int NIB     = s % PER_REG;

        logic [CODE_W-1:0] code;
        assign code = route_i[REG_IDX][CODE_W*NIB +: CODE_W];

        for (genvar l = 0; l < NLINE; l++) begin : g_line
            assign hit_o[l][s] = (code == CODE_W'(l + LINE_BASE));
        end
    end

endmodule

// File: rtl/icu_lines.sv
module icu_lines
    import icu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             src_i,
    input  logic [NSRC-1:0]             mask_i,
    input  logic [NLINE-1:0][NSRC-1:0]  hit_i,
    output logic [NLINE-1:0]            line_o
);

    logic [NSRC-1:0]  live;
    logic [NLINE-1:0] line_d;
    logic [NLINE-1:0] line_q;

    assign live = src_i & mask_i;

    for (genvar l = 0; l < NLINE; l++) begin : g_or
        assign line_d[l] = |(live & hit_i[l]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else
            line_q <= line_d;
    end

    assign line_o = line_q;

    AST_NO_SOURCE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_i) == '0) |-> (line_q == '0)); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_i) == '0) |-> (line_q == '0)); // R7

endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [31:0]       wr_data_i,
    output logic [31:0]       rd_data_o,
    output logic [4:0]        cpu_line_o
);

    logic [NSRC-1:0]             mask;
    logic [NROUTE-1:0][NSRC-1:0] route;
    logic [NLINE-1:0][NSRC-1:0]  hit;

    icu_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .mask_o    (mask),
        .route_o   (route)
    );

    icu_route u_route (
        .route_i (route),
        .hit_o   (hit)
    );

    icu_lines u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .mask_i (mask),
        .hit_i  (hit),
        .line_o (cpu_line_o)
    );

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> cpu_line_o == '0); // R1

endmodule

// File: tb/tb_routed_irq_ctrl.sv
module tb_routed_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic [4:0]  cpu_line;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] sh_mask;
    logic [31:0] sh_route [4];

    routed_irq_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wr_data_i  (wdata),
        .rd_data_o  (rd_data),
        .cpu_line_o (cpu_line)
    );

    always #2.5ns clk = ~clk;

    function automatic logic [4:0] model_lines(input logic [31:0] s, input logic [31:0] m);
        logic [4:0] o = '0;
        for (int i = 0; i < 32; i++) begin
            if (s[i] && m[i]) begin
                logic [3:0] code = sh_route[(31 - i) / 8][4*(i % 8) +: 4];
                if (code >= 4'd2 && code <= 4'd6) o[code - 4'd2] = 1'b1;
            end
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive inputs, predict lines from pre-edge state, update shadow, check
    task automatic cycle(input logic [31:0] s, input logic w, input logic [2:0] a,
                         input logic [31:0] d, input string tag);
        logic [4:0] exp;
        src = s; wr_en = w; addr = a; wdata = d;
        exp = model_lines(s, sh_mask);
        if (w && a == 3'd0) sh_mask = d;
        if (w && a >= 3'd2 && a <= 3'd5) sh_route[a - 3'd2] = d;
        @(posedge clk); #1ns;
        wr_en = 1'b0;
        check(tag, {27'd0, cpu_line}, {27'd0, exp});
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        addr = a; #1ns;
        check(tag, rd_data, exp);
    endtask

    initial begin
        #(200000 * 5ns);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        sh_mask = '0;
        sh_route[0] = 32'h3262_2225; sh_route[1] = 32'h5004_0000;
        sh_route[2] = '0; sh_route[3] = '0;
        repeat (3) @(posedge clk);
        #1ns rst_n = 1'b1;

        // R1 reset state
        check("R1 lines", {27'd0, cpu_line}, 32'd0);
        rd(3'd0, 32'h0, "R1 mask");
        rd(3'd2, 32'h3262_2225, "R1 route0");
        rd(3'd3, 32'h5004_0000, "R1 route1");
        rd(3'd4, 32'h0, "R1 route2");
        rd(3'd5, 32'h0, "R1 route3");

        // R6 sources high but all masked
        cycle('1, 1'b0, 3'd0, 0, "R6 masked");
        cycle('1, 1'b0, 3'd0, 0, "R6 masked");
        rd(3'd1, 32'hFFFF_FFFF, "R3 status unmasked");

        // R2 enable all
        cycle('0, 1'b1, 3'd0, 32'hFFFF_FFFF, "R2 write");
        rd(3'd0, 32'hFFFF_FFFF, "R2 readback");

        // R9 default routing
        cycle(32'h8000_0000, 1'b0, 3'd0, 0, "R9 src31");
        check("R9 src31 IP3", {27'd0, cpu_line}, 32'b00010);
        cycle(32'h2000_0000, 1'b0, 3'd0, 0, "R9 src29");
        check("R9 src29 IP6", {27'd0, cpu_line}, 32'b10000);
        cycle(32'h0010_0000, 1'b0, 3'd0, 0, "R9 src20");
        check("R9 src20 IP4", {27'd0, cpu_line}, 32'b00100);
        cycle(32'h0080_0000, 1'b0, 3'd0, 0, "R9 src23");
        check("R9 src23 IP5", {27'd0, cpu_line}, 32'b01000);
        cycle(32'h0000_0001, 1'b0, 3'd0, 0, "R5 src0");
        check("R5 src0 unrouted", {27'd0, cpu_line}, 32'd0);
        rd(3'd1, 32'h0000_0001, "R3 status");

        // R8 shared IP2: sources 30 and 28
        cycle(32'h5000_0000, 1'b0, 3'd0, 0, "R8 both");
        check("R8 both", {27'd0, cpu_line}, 32'b00001);
        cycle(32'h1000_0000, 1'b0, 3'd0, 0, "R8 one");
        check("R8 one left", {27'd0, cpu_line}, 32'b00001);
        cycle(32'h0000_0000, 1'b0, 3'd0, 0, "R8 none");
        check("R8 none", {27'd0, cpu_line}, 32'd0);

        // R7 mask clear timing
        cycle(32'h8000_0000, 1'b0, 3'd0, 0, "R7 setup");
        cycle(32'h8000_0000, 1'b1, 3'd0, 32'h0, "R7 write");
        check("R7 line held one edge", {27'd0, cpu_line}, 32'b00010);
        cycle(32'h8000_0000, 1'b0, 3'd0, 0, "R7 after");
        check("R7 line dropped", {27'd0, cpu_line}, 32'd0);
        cycle(32'h8000_0000, 1'b1, 3'd0, 32'h8000_0000, "R7 reenable");
        cycle(32'h8000_0000, 1'b0, 3'd0, 0, "R7 reenabled");
        check("R7 reenabled", {27'd0, cpu_line}, 32'b00010);

        // R4 status write ignored
        cycle(32'h8000_0000, 1'b1, 3'd1, 32'h0000_1234, "R4 write");
        rd(3'd0, 32'h8000_0000, "R4 mask kept");
        rd(3'd2, 32'h3262_2225, "R4 route0 kept");
        rd(3'd5, 32'h0, "R4 route3 kept");
        check("R4 lines", {27'd0, cpu_line}, 32'b00010);

        // R5 reprogram: source 3 -> IP6, source 2 -> code 7 (nowhere)
        cycle('0, 1'b1, 3'd0, 32'h0000_000C, "R5 mask");
        cycle('0, 1'b1, 3'd5, 32'h0000_6700, "R5 route3");
        rd(3'd5, 32'h0000_6700, "R5 readback");
        cycle(32'h0000_0008, 1'b0, 3'd0, 0, "R5 src3");
        check("R5 src3 IP6", {27'd0, cpu_line}, 32'b10000);
        cycle(32'h0000_0004, 1'b0, 3'd0, 0, "R5 src2");
        check("R5 code7 none", {27'd0, cpu_line}, 32'd0);

        // Random mix
        for (int it = 0; it < 600; it++) begin
            logic [2:0] a = 3'($urandom % 6);
            logic       w = ($urandom % 4) == 0;
            cycle($urandom, w, a, $urandom, "R6 random");
            if (($urandom % 8) == 0) rd(3'd1, src, "R3 random status");
            if (($urandom % 8) == 0) rd(3'd0, sh_mask, "R2 random mask");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule